// File: doc/BRIEF.md
# Data translation fault checker

This block takes one data memory access per cycle and decides whether the access may go ahead. Its inputs are the virtual address, the access size, the direction, the request qualifiers, the current privilege mode and the result of a translation lookup. It then either gives the physical address or names a fault class and the matching trap vector. The checks run in a fixed order, so that a single class and a single 6-bit flag word describe each failed access.

When a fault has to be recorded, three capture registers are loaded on the same clock edge. The first holds the faulting virtual address. The second holds a status word built from the opcode and destination-register fields of the current instruction, together with the flag word. The third holds a formatted address that points into the linear page table. Loads of page-table entries, requests that ask not to fault, and misspeculated accesses still report their class, but they leave the capture registers untouched. The lookup storage, its refill path and the trap dispatch sit outside this block.

Top module: `dxlat_fault_chk`

## Requirements
- R1: An access whose address has any bit set in `vaddr & (acc_size-1)` is an alignment fault (class code 1, vector 0x301). This check wins over every other check, and its flag word carries only the write bit (bit 0), which is set for writes.
- R2: An aligned address whose bits [VA_W-1:IVA_W-1] are not all equal is a page fault (class 2, vector 0x341). Its flags are write (if a write), access violation (bit 1) and bad address (bit 5).
- R3: A valid address with bits [IVA_W-1:IVA_W-2] equal to 2'b10 is a superpage access. In any mode other than kernel (mode 0) it is an access-violation fault (class 3, vector 0x381) with flags write (if a write) and access violation. In kernel mode it has no fault, and `pa` is the low PA_W bits of `vaddr`.
- R4: A lookup miss gives flags write (if a write) and miss (bit 4). Its class is 5 (vector 0x101) when `req_ptld` is set, and 4 (vector 0x201) otherwise.
- R5: On a hit with no fault, `pa` equals `{pte_ppn, vaddr[PAGE_SHIFT-1:0]}`. Whenever any fault is reported, `pa` is zero.
- R6: A write whose `pte_wr_en[cur_mode]` is clear is a page fault with flags write, access violation and, if `pte_fow` is set, fault-on-write (bit 3). A permitted write with `pte_fow` set is a page fault with flags write and fault-on-write.
- R7: A read whose `pte_rd_en[cur_mode]` is clear is an access-violation fault with flags access violation and, if `pte_for` is set, fault-on-read (bit 2). A permitted read with `pte_for` set is a page fault with the fault-on-read flag only.
- R8: On capture, `fault_stat` becomes `{inst[31:26], inst[25:21], flags}`: the opcode in bits 16:11, the register field in bits 10:6 and the flag word in bits 5:0.
- R9: On capture, `fault_va` takes `vaddr`, and `fault_form` takes `fmt_base | (vaddr >> PAGE_SHIFT) << 3`.
- R10: Capture happens only when `in_valid` is high and a fault is reported with `req_ptld`, `req_nofault` and `misspec` all low. Otherwise the three registers hold their values, and the class and vector are still reported.
- R11: With `in_valid` low, the class and vector are 0 and the capture registers hold their values. Reset clears all three capture registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Access present this cycle |
| vaddr | input | VA_W | Virtual address |
| acc_size | input | SIZE_W | Access size in bytes, a power of two |
| is_write | input | 1 | Access is a write |
| req_ptld | input | 1 | Access is a page-table-entry load |
| req_nofault | input | 1 | Access must not record a fault |
| misspec | input | 1 | Access is on a misspeculated path |
| cur_mode | input | MODE_W | Privilege mode, 0 is kernel |
| inst | input | INST_W | Instruction word of the access |
| fmt_base | input | VA_W | Page-table base for the formatted address |
| tlb_hit | input | 1 | Lookup found a translation |
| pte_ppn | input | PA_W-PAGE_SHIFT | Physical page number of the entry |
| pte_rd_en | input | 2**MODE_W | Read permission, one bit per mode |
| pte_wr_en | input | 2**MODE_W | Write permission, one bit per mode |
| pte_for | input | 1 | Entry faults on read |
| pte_fow | input | 1 | Entry faults on write |
| flt_class | output | 3 | Fault class: 0 none, 1 align, 2 page, 3 access violation, 4 miss, 5 page-table miss |
| flt_vec | output | 12 | Trap vector of the class, 0 when none |
| pa | output | PA_W | Physical address |
| fault_va | output | VA_W | Captured faulting address |
| fault_stat | output | 17 | Captured status word |
| fault_form | output | VA_W | Captured formatted address |

## Verification
The bench builds the block with a 32-bit virtual address, a 30-bit implemented region, a 24-bit physical address, 8 KiB pages, four modes and the superpage decoder enabled. With these values a single address constant can hit the sign-extension failure, the superpage window or the mapped region. The 4-bit size field reaches 8-byte accesses, so alignment is tested on several low-bit patterns. Four modes give permission vectors in which kernel and user bits differ, which is what separates the access-violation cases from the fault-on cases.

// File: rtl/dxf_pkg.sv
package dxf_pkg;
   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_ALIGN   = 3'd1,
      FC_PAGE    = 3'd2,
      FC_ACV     = 3'd3,
      FC_MISS    = 3'd4,
      FC_PTEMISS = 3'd5
   } fclass_e;

   localparam int FLAG_W   = 6;
   localparam int FL_WR    = 0;
   localparam int FL_ACV   = 1;
   localparam int FL_FOR   = 2;
   localparam int FL_FOW   = 3;
   localparam int FL_MISS  = 4;
   localparam int FL_BADVA = 5;
   localparam int VEC_W    = 12;
   localparam int STAT_W   = 6 + 5 + FLAG_W;

   function automatic logic [VEC_W-1:0] class_vec(input fclass_e c);
      case (c)
         FC_ALIGN:   return 12'h301;
         FC_PAGE:    return 12'h341;
         FC_ACV:     return 12'h381;
         FC_MISS:    return 12'h201;
         FC_PTEMISS: return 12'h101;
         default:    return '0;
      endcase
   endfunction
endpackage

// File: rtl/dxf_align.sv
module dxf_align #(
   parameter int VA_W   = 32,
   parameter int SIZE_W = 4
) (
   input  logic [VA_W-1:0]   vaddr,
   input  logic [SIZE_W-1:0] acc_size,
   output logic              misal
);
   logic [SIZE_W-1:0] low_mask;
   assign low_mask = acc_size - SIZE_W'(1);
   assign misal    = |(vaddr[SIZE_W-1:0] & low_mask);
endmodule

// File: rtl/dxf_classify.sv
module dxf_classify
   import dxf_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int IVA_W      = 30,
   parameter int PA_W       = 24,
   parameter int PAGE_SHIFT = 13,
   parameter int MODE_W     = 2,
   parameter bit SPAGE_EN   = 1'b1
) (
   input  logic                       misal,
   input  logic [VA_W-1:0]            vaddr,
   input  logic                       is_write,
   input  logic                       req_ptld,
   input  logic [MODE_W-1:0]          cur_mode,
   input  logic                       tlb_hit,
   input  logic [PA_W-PAGE_SHIFT-1:0] pte_ppn,
   input  logic [(1<<MODE_W)-1:0]     pte_rd_en,
   input  logic [(1<<MODE_W)-1:0]     pte_wr_en,
   input  logic                       pte_for,
   input  logic                       pte_fow,
   output fclass_e                    cls,
   output logic [FLAG_W-1:0]          flags,
   output logic [PA_W-1:0]            pa_raw
);
   localparam int HI_W = VA_W - IVA_W + 1;

   logic [HI_W-1:0] hi_bits;
   logic            va_ok;
   logic            sp_hit;
   logic            kern;

   assign hi_bits = vaddr[VA_W-1:IVA_W-1];
   assign va_ok   = (&hi_bits) | ~(|hi_bits);
   assign kern    = (cur_mode == '0);

   generate
      if (SPAGE_EN) begin : g_spage
         assign sp_hit = va_ok && (vaddr[IVA_W-1:IVA_W-2] == 2'b10);
      end else begin : g_nospage
         assign sp_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      cls    = FC_NONE;
      flags  = '0;
      pa_raw = '0;
      if (misal) begin
         cls          = FC_ALIGN;
         flags[FL_WR] = is_write;
      end else if (!va_ok) begin
         cls             = FC_PAGE;
         flags[FL_WR]    = is_write;
         flags[FL_ACV]   = 1'b1;
         flags[FL_BADVA] = 1'b1;
      end else if (sp_hit) begin
         if (!kern) begin
            cls           = FC_ACV;
            flags[FL_WR]  = is_write;
            flags[FL_ACV] = 1'b1;
         end else begin
            pa_raw = vaddr[PA_W-1:0];
         end
      end else if (!tlb_hit) begin
         cls            = req_ptld ? FC_PTEMISS : FC_MISS;
         flags[FL_WR]   = is_write;
         flags[FL_MISS] = 1'b1;
      end else begin
         pa_raw = {pte_ppn, vaddr[PAGE_SHIFT-1:0]};
         if (is_write) begin
            if (!pte_wr_en[cur_mode]) begin
               cls           = FC_PAGE;
               flags[FL_WR]  = 1'b1;
               flags[FL_ACV] = 1'b1;
               flags[FL_FOW] = pte_fow;
            end else if (pte_fow) begin
               cls           = FC_PAGE;
               flags[FL_WR]  = 1'b1;
               flags[FL_FOW] = 1'b1;
            end
         end else begin
            if (!pte_rd_en[cur_mode]) begin
               cls           = FC_ACV;
               flags[FL_ACV] = 1'b1;
               flags[FL_FOR] = pte_for;
            end else if (pte_for) begin
               cls           = FC_PAGE;
               flags[FL_FOR] = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dxf_fregs.sv
module dxf_fregs
   import dxf_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PAGE_SHIFT = 13,
   parameter int INST_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [VA_W-1:0]   vaddr,
   input  logic [INST_W-1:0] inst,
   input  logic [VA_W-1:0]   fmt_base,
   input  logic [FLAG_W-1:0] flags,
   output logic [VA_W-1:0]   fault_va,
   output logic [STAT_W-1:0] fault_stat,
   output logic [VA_W-1:0]   fault_form
);
   localparam int OPC_LSB = INST_W - 6;
   localparam int RA_LSB  = INST_W - 11;

   logic [VA_W-1:0]   vpn_sh;
   logic [STAT_W-1:0] stat_d;

   assign vpn_sh = {{(PAGE_SHIFT-3){1'b0}}, vaddr[VA_W-1:PAGE_SHIFT], 3'b000};
   assign stat_d = {inst[INST_W-1:OPC_LSB], inst[OPC_LSB-1:RA_LSB], flags};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_va   <= '0;
         fault_stat <= '0;
         fault_form <= '0;
      end else if (cap) begin
         fault_va   <= vaddr;
         fault_stat <= stat_d;
         fault_form <= fmt_base | vpn_sh;
      end
   end
endmodule

// File: rtl/dxlat_fault_chk.sv
module dxlat_fault_chk
   import dxf_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int IVA_W      = 30,
   parameter int PA_W       = 24,
   parameter int PAGE_SHIFT = 13,
   parameter int SIZE_W     = 4,
   parameter int MODE_W     = 2,
   parameter int INST_W     = 32,
   parameter bit SPAGE_EN   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [VA_W-1:0]            vaddr,
   input  logic [SIZE_W-1:0]          acc_size,
   input  logic                       is_write,
   input  logic                       req_ptld,
   input  logic                       req_nofault,
   input  logic                       misspec,
   input  logic [MODE_W-1:0]          cur_mode,
   input  logic [INST_W-1:0]          inst,
   input  logic [VA_W-1:0]            fmt_base,
   input  logic                       tlb_hit,
   input  logic [PA_W-PAGE_SHIFT-1:0] pte_ppn,
   input  logic [(1<<MODE_W)-1:0]     pte_rd_en,
   input  logic [(1<<MODE_W)-1:0]     pte_wr_en,
   input  logic                       pte_for,
   input  logic                       pte_fow,
   output logic [2:0]                 flt_class,
   output logic [11:0]                flt_vec,
   output logic [PA_W-1:0]            pa,
   output logic [VA_W-1:0]            fault_va,
   output logic [16:0]                fault_stat,
   output logic [VA_W-1:0]            fault_form
);
   generate
      if (PAGE_SHIFT <= 3 || PAGE_SHIFT >= PA_W) begin : g_bad_page
         $error("PAGE_SHIFT must lie between 4 and PA_W-1");
      end
      if (IVA_W < 3 || IVA_W > VA_W || PA_W > VA_W) begin : g_bad_va
         $error("IVA_W and PA_W must fit within VA_W");
      end
      if (SIZE_W > PAGE_SHIFT || INST_W < 11) begin : g_bad_misc
         $error("SIZE_W or INST_W out of range");
      end
   endgenerate

   logic              misal;
   fclass_e           cls;
   logic [FLAG_W-1:0] flags;
   logic [PA_W-1:0]   pa_raw;
   fclass_e           cls_q;
   logic              cap;

   dxf_align #(.VA_W(VA_W), .SIZE_W(SIZE_W)) u_align (
      .vaddr(vaddr), .acc_size(acc_size), .misal(misal)
   );

   dxf_classify #(
      .VA_W(VA_W), .IVA_W(IVA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT),
      .MODE_W(MODE_W), .SPAGE_EN(SPAGE_EN)
   ) u_cls (
      .misal(misal), .vaddr(vaddr), .is_write(is_write), .req_ptld(req_ptld),
      .cur_mode(cur_mode), .tlb_hit(tlb_hit), .pte_ppn(pte_ppn),
      .pte_rd_en(pte_rd_en), .pte_wr_en(pte_wr_en), .pte_for(pte_for),
      .pte_fow(pte_fow), .cls(cls), .flags(flags), .pa_raw(pa_raw)
   );

   assign cls_q     = in_valid ? cls : FC_NONE;
   assign flt_class = cls_q;
   assign flt_vec   = class_vec(cls_q);
   assign pa        = (in_valid && cls == FC_NONE) ? pa_raw : '0;
   assign cap       = in_valid && (cls != FC_NONE) && !req_ptld && !req_nofault && !misspec;

   dxf_fregs #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .INST_W(INST_W)) u_fregs (
      .clk(clk), .rst_n(rst_n), .cap(cap), .vaddr(vaddr), .inst(inst),
      .fmt_base(fmt_base), .flags(flags), .fault_va(fault_va),
      .fault_stat(fault_stat), .fault_form(fault_form)
   );
endmodule

// File: rtl/dxf_chk.sv
module dxf_chk #(
   parameter int VA_W       = 32,
   parameter int PA_W       = 24,
   parameter int PAGE_SHIFT = 13,
   parameter int SIZE_W     = 4,
   parameter int INST_W     = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [VA_W-1:0]   vaddr,
   input logic [SIZE_W-1:0] acc_size,
   input logic              req_ptld,
   input logic              req_nofault,
   input logic              misspec,
   input logic [INST_W-1:0] inst,
   input logic [2:0]        flt_class,
   input logic [11:0]       flt_vec,
   input logic [PA_W-1:0]   pa,
   input logic [VA_W-1:0]   fault_va,
   input logic [16:0]       fault_stat,
   input logic [VA_W-1:0]   fault_form
);
   logic bad_align;
   logic will_cap;
   assign bad_align = |(vaddr[SIZE_W-1:0] & (acc_size - SIZE_W'(1)));
   assign will_cap  = in_valid && (flt_class != 3'd0) && !req_ptld && !req_nofault && !misspec;

   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (flt_class == 3'd0 && flt_vec == 12'h000));

   a_r1_align_first: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bad_align) |-> (flt_class == 3'd1 && flt_vec == 12'h301));

   a_r3_acv_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_class == 3'd3) |-> (flt_vec == 12'h381));

   a_r5_pa_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_class != 3'd0) |-> (pa == '0));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !will_cap |=> ($stable(fault_va) && $stable(fault_stat) && $stable(fault_form)));

   a_r9_capture_va: assert property (@(posedge clk) disable iff (!rst_n)
      will_cap |=> (fault_va == $past(vaddr)));

   a_r8_capture_stat: assert property (@(posedge clk) disable iff (!rst_n)
      will_cap |=> (fault_stat[16:6] == {$past(inst[INST_W-1:INST_W-6]), $past(inst[INST_W-7:INST_W-11])}));
endmodule

bind dxlat_fault_chk dxf_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .SIZE_W(SIZE_W), .INST_W(INST_W)
) u_chk (.*);

// File: tb/sim_dxlat_fault_chk.sv
`timescale 1ns/1ps
module sim_dxlat_fault_chk;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v = 1'b0;
   logic [31:0] va = '0;
   logic [3:0]  sz = 4'd1;
   logic        wr = 1'b0, ptld = 1'b0, nof = 1'b0, msp = 1'b0;
   logic [1:0]  md = '0;
   logic [31:0] ins = '0, base = '0;
   logic        hit = 1'b1;
   logic [10:0] ppn = '0;
   logic [3:0]  rden = 4'hF, wren = 4'hF;
   logic        fr = 1'b0, fw = 1'b0;
   logic [2:0]  o_cls;
   logic [11:0] o_vec;
   logic [23:0] o_pa;
   logic [31:0] o_fva, o_ffm;
   logic [16:0] o_fst;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct {
      logic [2:0]  cls;
      logic [11:0] vec;
      logic [23:0] pa;
      logic [31:0] fva;
      logic [16:0] fst;
      logic [31:0] ffm;
      string       tag;
   } exp_t;
   exp_t q[$];
   logic [31:0] m_fva = '0, m_ffm = '0;
   logic [16:0] m_fst = '0;

   always #10 clk = ~clk;

   dxlat_fault_chk #(
      .VA_W(32), .IVA_W(30), .PA_W(24), .PAGE_SHIFT(13), .SIZE_W(4),
      .MODE_W(2), .INST_W(32), .SPAGE_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(v), .vaddr(va), .acc_size(sz),
      .is_write(wr), .req_ptld(ptld), .req_nofault(nof), .misspec(msp),
      .cur_mode(md), .inst(ins), .fmt_base(base), .tlb_hit(hit), .pte_ppn(ppn),
      .pte_rd_en(rden), .pte_wr_en(wren), .pte_for(fr), .pte_fow(fw),
      .flt_class(o_cls), .flt_vec(o_vec), .pa(o_pa), .fault_va(o_fva),
      .fault_stat(o_fst), .fault_form(o_ffm)
   );

   task automatic defaults();
      v = 1'b1; va = 32'h0001_2340; sz = 4'd4; wr = 1'b0; ptld = 1'b0; nof = 1'b0;
      msp = 1'b0; md = 2'd0; ins = 32'hA5C3_0000; base = 32'h2000_0000;
      hit = 1'b1; ppn = 11'h155; rden = 4'hF; wren = 4'hF; fr = 1'b0; fw = 1'b0;
   endtask

   // Expected outcome worked out from the requirement text.
   task automatic go(input string tag);
      exp_t e;
      logic [2:0] c;
      logic [5:0] f;
      logic [23:0] p;
      logic okva, spg;
      c = 3'd0; f = 6'd0; p = '0;
      okva = (va[31:29] == 3'b000) || (va[31:29] == 3'b111);
      spg  = okva && (va[29:28] == 2'b10);
      if ((va[3:0] & (sz - 4'd1)) != 4'd0) begin c = 3'd1; f = {5'd0, wr}; end
      else if (!okva) begin c = 3'd2; f = 6'b100010 | {5'd0, wr}; end
      else if (spg) begin
         if (md != 2'd0) begin c = 3'd3; f = 6'b000010 | {5'd0, wr}; end
         else p = va[23:0];
      end
      else if (!hit) begin c = ptld ? 3'd5 : 3'd4; f = 6'b010000 | {5'd0, wr}; end
      else begin
         p = {ppn, va[12:0]};
         if (wr) begin
            if (!wren[md]) begin c = 3'd2; f = {2'b00, fw, 3'b011}; end
            else if (fw) begin c = 3'd2; f = 6'b001001; end
         end else begin
            if (!rden[md]) begin c = 3'd3; f = {3'b000, fr, 2'b10}; end
            else if (fr) begin c = 3'd2; f = 6'b000100; end
         end
      end
      if (!v) c = 3'd0;
      e.cls = c;
      case (c)
         3'd1: e.vec = 12'h301;
         3'd2: e.vec = 12'h341;
         3'd3: e.vec = 12'h381;
         3'd4: e.vec = 12'h201;
         3'd5: e.vec = 12'h101;
         default: e.vec = 12'h000;
      endcase
      e.pa = (c == 3'd0 && v) ? p : 24'd0;
      if (v && c != 3'd0 && !ptld && !nof && !msp) begin
         m_fva = va;
         m_fst = {ins[31:26], ins[25:21], f};
         m_ffm = base | ({13'd0, va[31:13]} << 3);
      end
      e.fva = m_fva; e.fst = m_fst; e.ffm = m_ffm; e.tag = tag;
      q.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: compare one expected item per cycle, after the edge settles.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (o_cls !== e.cls || o_vec !== e.vec || o_pa !== e.pa ||
                o_fva !== e.fva || o_fst !== e.fst || o_ffm !== e.ffm) begin
               fails++;
               $display("FAIL %s: got cls=%0d vec=%h pa=%h fva=%h fst=%h ffm=%h, expected cls=%0d vec=%h pa=%h fva=%h fst=%h ffm=%h",
                        e.tag, o_cls, o_vec, o_pa, o_fva, o_fst, o_ffm,
                        e.cls, e.vec, e.pa, e.fva, e.fst, e.ffm);
            end
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (o_fva !== 32'd0 || o_fst !== 17'd0 || o_ffm !== 32'd0 || o_cls !== 3'd0) begin
         fails++;
         $display("FAIL R11 reset: got fva=%h fst=%h ffm=%h cls=%0d, expected all zero",
                  o_fva, o_fst, o_ffm, o_cls);
      end
      defaults(); go("R5 read hit kernel");
      defaults(); wr = 1; va = 32'h0000_7FF8; sz = 4'd8; ppn = 11'h7FF; go("R5 write hit");
      defaults(); wr = 1; va = 32'h0001_0002; go("R1 misaligned write");
      defaults(); va = 32'h0001_0004; sz = 4'd8; hit = 0; go("R1 misalign beats miss");
      defaults(); va = 32'h4000_0000; wr = 1; go("R2 bad address write");
      defaults(); va = 32'hC000_0010; ins = 32'h1234_5678; go("R2 bad address read, R8 status");
      defaults(); va = 32'hE000_1000; md = 2'd1; go("R3 superpage user");
      defaults(); va = 32'hE0AB_C010; md = 2'd0; wr = 1; go("R3 superpage kernel pa");
      defaults(); hit = 0; wr = 1; go("R4 normal miss write");
      defaults(); hit = 0; ptld = 1; va = 32'h0003_0000; go("R4 pte miss, R10 no capture");
      defaults(); wr = 1; md = 2'd2; wren = 4'b1011; fw = 1; go("R6 write denied fow");
      defaults(); wr = 1; md = 2'd2; wren = 4'b1011; go("R6 write denied");
      defaults(); wr = 1; fw = 1; go("R6 write fow only");
      defaults(); md = 2'd3; rden = 4'b0111; fr = 1; go("R7 read denied for");
      defaults(); md = 2'd3; rden = 4'b0111; go("R7 read denied");
      defaults(); fr = 1; va = 32'hFFFF_E000; base = 32'h0F00_0000; go("R7 read for only, R9 form");
      defaults(); hit = 0; nof = 1; va = 32'h0005_5000; go("R10 nofault class kept");
      defaults(); hit = 0; msp = 1; va = 32'h0006_6000; go("R10 misspec class kept");
      defaults(); v = 0; va = 32'h4000_0001; hit = 0; go("R11 idle ignored");
      for (int i = 0; i < 200; i++) begin
         defaults();
         va   = $urandom;
         if (i % 3 == 0) va[31:29] = va[29] ? 3'b111 : 3'b000;
         sz   = 4'd1 << ($urandom % 4);
         wr   = $urandom % 2;
         ptld = ($urandom % 5) == 0;
         nof  = ($urandom % 7) == 0;
         msp  = ($urandom % 7) == 0;
         md   = $urandom % 4;
         ins  = $urandom;
         base = $urandom;
         hit  = ($urandom % 4) != 0;
         ppn  = $urandom;
         rden = $urandom; wren = $urandom;
         fr   = $urandom % 2; fw = $urandom % 2;
         v    = ($urandom % 8) != 0;
         go("R1/R2/R3/R4/R6/R7/R9 random");
      end
      v = 0;
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule